// File: doc/BRIEF.md
# Jump Target Translation Cache

This block keeps recently used pairs of source-program address and translated-code address, so that a binary-translation engine can resolve an indirect jump without running the software map walk. A lookup presents a source PC and, in the same cycle, gets back a hit flag and the translated PC. The same port also takes the target that the branch predictor has already chosen for fetch. From these it returns a fetch decision: keep going, steer fetch to the cached translated PC, or take the fall-through path into the software lookup routine.

The store is two-way set associative. The source PC is folded by XOR into a set index, and the full source PC serves as the tag. Software installs new pairs through a fill port. A single-cycle invalidate input empties the cache when the code cache is flushed.

Top module: `jump_xlate_cache`

## Requirements
- R1: The set index is the XOR fold of lk_spc[PC_W-1:2]. Index bit j is the XOR of every bit lk_spc[2+j+k*SET_BITS] for k = 0, 1, .... Each of the 2^SET_BITS sets holds 2 ways. Two PCs with the same fold compete for the same 2 ways, and PCs with different folds do not disturb each other.
- R2: The lookup outputs are combinational. When a valid way of the indexed set holds exactly lk_spc, lk_hit is 1 and lk_tpc is that way's translated PC. Otherwise lk_hit is 0 and lk_tpc is 0.
- R3: With lk_valid=1 and a hit whose lk_tpc equals lk_pred_tpc, fetch_act is 2'b00 (continue).
- R4: With lk_valid=1 and a hit whose lk_tpc differs from lk_pred_tpc, fetch_act is 2'b01 (redirect to lk_tpc). The value 2'b11 never appears.
- R5: With lk_valid=1 and a miss, fetch_act is 2'b10 (redirect to the fall-through software lookup). With lk_valid=0, fetch_act is 2'b00.
- R6: A fill (fill_valid=1) installs fill_spc→fill_tpc at the clock edge. A lookup of fill_spc hits with fill_tpc from the next cycle on.
- R7: A fill whose fill_spc is already valid in its set overwrites that way's translated PC. It never creates a second copy, and the other way is kept.
- R8: A fill with no matching tag first uses an invalid way (way 0 before way 1). If both ways are valid, it replaces the least recently used way. A lookup hit with lk_valid=1 and a fill each mark the touched way as most recently used. When both touch the same set in the same cycle, the fill wins.
- R9: inv_all=1 clears every entry at the clock edge, so every lookup misses in the next cycle. A fill in the same cycle is dropped.
- R10: After reset every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request; enables the fetch decision and the LRU update |
| lk_spc | input | PC_W | Source PC to look up |
| lk_pred_tpc | input | PC_W | Fetch target already chosen by the branch predictor |
| lk_hit | output | 1 | Lookup hit |
| lk_tpc | output | PC_W | Cached translated PC (0 on a miss) |
| fetch_act | output | 2 | 00 continue, 01 redirect to lk_tpc, 10 redirect to fall-through |
| fill_valid | input | 1 | Install a mapping |
| fill_spc | input | PC_W | Source PC of the mapping |
| fill_tpc | input | PC_W | Translated PC of the mapping |
| inv_all | input | 1 | Clear all entries |

## Verification
The bench uses the default PC_W=32 and SET_BITS=4, which gives 16 sets and a fold over 30 address bits. With these values, PCs that differ only in bits 26, 27, 30 and 31 land in one set. That lets the bench exercise eviction, LRU order and in-place refill through the highest folded bits. PCs that differ in their low bits land in separate sets, which checks that sets stay apart.

// File: rtl/jump_xlate_cache.sv
module jump_xlate_cache #(
  parameter int PC_W     = 32,
  parameter int SET_BITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_spc,
  input  logic [PC_W-1:0] lk_pred_tpc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_tpc,
  output logic [1:0]      fetch_act,
  input  logic            fill_valid,
  input  logic [PC_W-1:0] fill_spc,
  input  logic [PC_W-1:0] fill_tpc,
  input  logic            inv_all
);
  localparam int SETS = 1 << SET_BITS;

  function automatic logic [SET_BITS-1:0] fold(input logic [PC_W-1:0] pc);
    logic [SET_BITS-1:0] r;
    r = '0;
    for (int i = 0; i < PC_W - 2; i++) r[i % SET_BITS] = r[i % SET_BITS] ^ pc[i + 2];
    return r;
  endfunction

  logic [PC_W-1:0]     tag_q [SETS][2];
  logic [PC_W-1:0]     tpc_q [SETS][2];
  logic [1:0]          vld_q [SETS];
  logic [SETS-1:0]     lru_q;

  logic [SET_BITS-1:0] lk_set, f_set;
  logic [1:0]          lk_match, f_match;
  logic                f_way;

  assign lk_set = fold(lk_spc);
  assign f_set  = fold(fill_spc);

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_spc);
    assign f_match[w]  = vld_q[f_set][w]  && (tag_q[f_set][w]  == fill_spc);
  end

  assign lk_hit = |lk_match;
  assign lk_tpc = lk_match[0] ? tpc_q[lk_set][0] :
                  lk_match[1] ? tpc_q[lk_set][1] : '0;

  assign fetch_act = !lk_valid               ? 2'b00 :
                     !lk_hit                 ? 2'b10 :
                     (lk_pred_tpc == lk_tpc) ? 2'b00 : 2'b01;

  assign f_way = (|f_match)         ? f_match[1] :
                 !vld_q[f_set][0]   ? 1'b0 :
                 !vld_q[f_set][1]   ? 1'b1 : lru_q[f_set];

  always_ff @(posedge clk) begin
    if (!rst_n || inv_all) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      if (!rst_n) lru_q <= '0;
    end else begin
      if (lk_valid && lk_hit) lru_q[lk_set] <= !lk_match[1];
      if (fill_valid) begin
        vld_q[f_set][f_way] <= 1'b1;
        lru_q[f_set]        <= !f_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !inv_all && fill_valid) begin
      tag_q[f_set][f_way] <= fill_spc;
      tpc_q[f_set][f_way] <= fill_tpc;
    end
  end
endmodule

module jump_xlate_cache_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_hit,
  input logic [PC_W-1:0] lk_spc,
  input logic [PC_W-1:0] lk_tpc,
  input logic [1:0]      fetch_act,
  input logic [1:0]      lk_match,
  input logic            fill_valid,
  input logic [PC_W-1:0] fill_spc,
  input logic [PC_W-1:0] fill_tpc,
  input logic            inv_all
);
  a_r4_act_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_act != 2'b11);

  a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

  a_r10_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit);

  a_r6_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_all) ##1 (lk_spc == $past(fill_spc))
      |-> (lk_hit && lk_tpc == $past(fill_tpc)));
endmodule

bind jump_xlate_cache jump_xlate_cache_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_spc(lk_spc), .lk_tpc(lk_tpc),
  .fetch_act(fetch_act), .lk_match(lk_match), .fill_valid(fill_valid),
  .fill_spc(fill_spc), .fill_tpc(fill_tpc), .inv_all(inv_all)
);

// File: tb/jump_xlate_cache_bench.sv
module jump_xlate_cache_bench;
  localparam int PC_W = 32;
  localparam int SB   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            lk_valid = 1'b0;
  logic [PC_W-1:0] lk_spc = '0, lk_pred_tpc = '0;
  logic            lk_hit;
  logic [PC_W-1:0] lk_tpc;
  logic [1:0]      fetch_act;
  logic            fill_valid = 1'b0;
  logic [PC_W-1:0] fill_spc = '0, fill_tpc = '0;
  logic            inv_all = 1'b0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  jump_xlate_cache #(.PC_W(PC_W), .SET_BITS(SB)) u_jump_xlate_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_spc(lk_spc),
    .lk_pred_tpc(lk_pred_tpc), .lk_hit(lk_hit), .lk_tpc(lk_tpc),
    .fetch_act(fetch_act), .fill_valid(fill_valid), .fill_spc(fill_spc),
    .fill_tpc(fill_tpc), .inv_all(inv_all));

  function automatic logic [SB-1:0] idx_of(input logic [PC_W-1:0] pc);
    logic [SB-1:0] r = '0;
    logic [PC_W-1:0] sh = pc >> 2;
    for (int c = 0; c < (PC_W - 2 + SB - 1) / SB; c++) begin
      r  = r ^ sh[SB-1:0];
      sh = sh >> SB;
    end
    return r;
  endfunction

  function automatic logic [PC_W-1:0] same_set(input logic [PC_W-1:0] base, input int k);
    return base ^ (PC_W'(k) << 26) ^ (PC_W'(k) << 30);
  endfunction

  task automatic fill(input logic [PC_W-1:0] spc, input logic [PC_W-1:0] tpc, input logic inv);
    @(negedge clk);
    fill_valid = 1'b1; fill_spc = spc; fill_tpc = tpc; inv_all = inv;
    @(negedge clk);
    fill_valid = 1'b0; inv_all = 1'b0;
  endtask

  task automatic look(input logic vld, input logic [PC_W-1:0] spc, input logic [PC_W-1:0] pred,
                      input logic ehit, input logic [PC_W-1:0] etpc, input logic [1:0] eact,
                      input string req);
    @(negedge clk);
    lk_valid = vld; lk_spc = spc; lk_pred_tpc = pred;
    #1;
    checks++;
    if (lk_hit !== ehit || lk_tpc !== etpc || fetch_act !== eact) begin
      failures++;
      $display("FAIL %s spc=%h: hit=%b tpc=%h act=%b expected hit=%b tpc=%h act=%b",
               req, spc, lk_hit, lk_tpc, fetch_act, ehit, etpc, eact);
    end
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic t_reset;
    look(1, 32'h0000_1234, 32'h0, 0, 32'h0, 2'b10, "R10 empty after reset");
    look(1, 32'h8000_0000, 32'h0, 0, 32'h0, 2'b10, "R5 miss redirects to fall-through");
    look(0, 32'h8000_0000, 32'h0, 0, 32'h0, 2'b00, "R5 idle lookup continues");
  endtask

  task automatic t_basic;
    fill(32'h0000_0004, 32'hA000_0010, 0);
    look(1, 32'h0000_0004, 32'hA000_0010, 1, 32'hA000_0010, 2'b00, "R3 hit matching prediction");
    look(1, 32'h0000_0004, 32'h1111_0000, 1, 32'hA000_0010, 2'b01, "R4 hit with wrong prediction");
    look(0, 32'h0000_0004, 32'h1111_0000, 1, 32'hA000_0010, 2'b00, "R2 hit data without request");
    look(1, 32'h0000_0005, 32'hA000_0010, 0, 32'h0, 2'b10, "R2 near tag misses");
  endtask

  task automatic t_sets;
    fill(32'h0000_0008, 32'hB000_0008, 0);
    fill(32'h0000_000C, 32'hB000_000C, 0);
    if (idx_of(32'h0000_0004) == idx_of(32'h0000_0008)) $display("bench note: index overlap");
    look(1, 32'h0000_0004, 32'h0, 1, 32'hA000_0010, 2'b01, "R1 distinct sets keep entry");
    look(1, 32'h0000_0008, 32'hB000_0008, 1, 32'hB000_0008, 2'b00, "R1 second set");
    look(1, 32'h0000_000C, 32'hB000_000C, 1, 32'hB000_000C, 2'b00, "R6 third set fill visible");
  endtask

  task automatic t_lru;
    logic [PC_W-1:0] a, b, c;
    a = same_set(32'h0000_0100, 1);
    b = same_set(32'h0000_0100, 2);
    c = same_set(32'h0000_0100, 3);
    fill(a, 32'hC000_0001, 0);
    fill(b, 32'hC000_0002, 0);
    look(1, a, 32'hC000_0001, 1, 32'hC000_0001, 2'b00, "R8 touch oldest way");
    fill(c, 32'hC000_0003, 0);
    look(1, a, 32'hC000_0001, 1, 32'hC000_0001, 2'b00, "R8 recently used way kept");
    look(1, b, 32'hC000_0002, 0, 32'h0, 2'b10, "R1 R8 least recently used way evicted");
    look(1, c, 32'hC000_0003, 1, 32'hC000_0003, 2'b00, "R8 new entry in victim way");
  endtask

  task automatic t_dedup;
    logic [PC_W-1:0] a, b;
    a = same_set(32'h0000_0200, 1);
    b = same_set(32'h0000_0200, 2);
    fill(a, 32'hD000_0001, 0);
    fill(b, 32'hD000_0002, 0);
    look(1, a, 32'h0, 1, 32'hD000_0001, 2'b01, "R8 hit makes way 1 the victim");
    fill(a, 32'hD000_00AA, 0);
    look(1, a, 32'hD000_00AA, 1, 32'hD000_00AA, 2'b00, "R7 refill updates translated PC");
    look(1, b, 32'hD000_0002, 1, 32'hD000_0002, 2'b00, "R7 refill keeps other way");
  endtask

  task automatic t_inv;
    fill(32'h0000_0040, 32'hE000_0040, 0);
    fill(32'h0000_0080, 32'hE000_0080, 1);
    look(1, 32'h0000_0040, 32'h0, 0, 32'h0, 2'b10, "R9 entry cleared");
    look(1, 32'h0000_0080, 32'h0, 0, 32'h0, 2'b10, "R9 same-cycle fill dropped");
    look(1, 32'h0000_0004, 32'h0, 0, 32'h0, 2'b10, "R9 older entry cleared");
    fill(32'h0000_0040, 32'hE000_0041, 0);
    look(1, 32'h0000_0040, 32'hE000_0041, 1, 32'hE000_0041, 2'b00, "R6 fill after flush");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_sets;
    t_lru;
    t_dedup;
    t_inv;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule